// File: doc/BRIEF.md
# Grouped Pin Interrupt Aggregator

This block collects interrupt requests from a large set of general-purpose pins. The pins are arranged as up to 21 groups of at most 8 pins each. Every pin gets a 4-bit trigger code, a mask bit and a pending bit. The block does four things:

- It passes the raw pins through a two-flop synchroniser.
- It evaluates each pin's chosen level or edge condition.
- It latches events into sticky pending bits.
- It drives one shared interrupt line that is high whenever any pin is both pending and unmasked.

Software reaches the three register banks (trigger, mask, pending) over a simple single-cycle read/write bus. Each group owns one 32-bit word in each bank.

An interrupt handler reads the pending words, skips any masked pins and services the pins that remain. It then acknowledges each serviced pin by writing a one to that pin's pending bit. A pin whose level condition still holds stays pending. Events keep latching while a pin is masked, so unmasking a pin with a stored event raises the interrupt line at once.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every trigger, mask and pending word reads 0 and `irq_out` is low. No pending bit is set until the synchroniser holds real pin samples; the check uses pins held high during and after reset.
- R2: Bank layout and read timing:
  - The trigger word of group g sits at byte address 0x700+4g, its mask word at 0x900+4g and its pending word at 0xA00+4g.
  - Read data appears on `bus_rdata` in the cycle after the read request.
  - Pin p uses trigger bits 4p+3..4p, and bit p of the mask and pending words.
  - Mask bits 31..8 and pending bits 31..8 always read 0.
- R3: Trigger codes set the pending bit as follows:
  - 0: set while the synchronised pin is low.
  - 1: set while the pin is high.
  - 2: set on a falling edge.
  - 3: set on a rising edge.
  - 4: set on either edge.
  - A pin change made before a clock edge reaches the pending bit at the third rising edge.
- R4: Trigger codes 5 to 15 never set the pending bit, whatever the pin does.
- R5: A pending bit stays set until software writes a 1 to its position in the group's pending word. Writing 0 leaves it unchanged, and a 1 clears only that pin.
- R6: A detection in the same cycle as a clear of that bit wins, so the bit stays set. A level-mode bit that is cleared while its level condition still holds remains set.
- R7: Mask and interrupt line:
  - `irq_out` is high exactly when some pin has its pending bit set and its mask bit clear.
  - Mask bit 1 disables a pin, but its pending bit still latches.
  - Clearing the mask of a pending pin raises `irq_out` in the cycle after the write.
- R8: Writes that are misaligned, that fall outside the three banks, or that name a group at or above the group count are ignored. Reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_GROUPS*PINS | Raw pin levels; pin p of group g is bit g*PINS+p |
| bus_sel | input | 1 | Bus request valid for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions take for granted that every bus request lasts exactly one cycle. They also assume that a pending bit can only become set through a detection in the cycle before. Pins are taken as free-running inputs that need not meet any timing relation to the clock.

The stimulus keeps within these assumptions in three ways:
- It changes pins and bus signals only at falling clock edges.
- It leaves at least six cycles after each pin change before reading back.
- It holds every pin high whenever the all-zero trigger code (level-low) is in force, so no stray pending bits appear outside the pin under test.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned TRIG_FIELD_W = 4;

    typedef enum logic [3:0] {
        TRIG_LEVEL_LOW  = 4'd0,
        TRIG_LEVEL_HIGH = 4'd1,
        TRIG_EDGE_FALL  = 4'd2,
        TRIG_EDGE_RISE  = 4'd3,
        TRIG_EDGE_ANY   = 4'd4
    } trig_mode_e;

    typedef enum logic [1:0] {
        BANK_NONE,
        BANK_TRIG,
        BANK_MASK,
        BANK_PEND
    } bank_e;

    // Evaluate one pin's trigger condition from its current and previous sample.
    function automatic logic trig_fire(input logic [3:0] code,
                                       input logic       cur,
                                       input logic       prev);
        logic fire;
        case (code)
            TRIG_LEVEL_LOW:  fire = !cur;
            TRIG_LEVEL_HIGH: fire = cur;
            TRIG_EDGE_FALL:  fire = prev && !cur;
            TRIG_EDGE_RISE:  fire = !prev && cur;
            TRIG_EDGE_ANY:   fire = prev ^ cur;
            default:         fire = 1'b0;
        endcase
        return fire;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_raw,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev,
    output logic             primed
);
    localparam logic [1:0] FILL_DONE = 2'd3;

    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
        logic [WIDTH-1:0] last;
        logic [1:0]       fill;
    } sync_state_t;

    sync_state_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stage1 = pin_raw;
        sync_d.stage2 = sync_q.stage1;
        sync_d.last   = sync_q.stage2;
        if (sync_q.fill != FILL_DONE) begin
            sync_d.fill = sync_q.fill + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign cur    = sync_q.stage2;
    assign prev   = sync_q.last;
    assign primed = (sync_q.fill == FILL_DONE);
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PINS = 8
) (
    input  logic [PINS*TRIG_FIELD_W-1:0] trig_cfg,
    input  logic [PINS-1:0]              cur,
    input  logic [PINS-1:0]              prev,
    input  logic                         enable,
    output logic [PINS-1:0]              hit
);
    for (genvar p = 0; p < PINS; p++) begin : g_pin
        assign hit[p] = enable &&
                        trig_fire(trig_cfg[p*TRIG_FIELD_W +: TRIG_FIELD_W], cur[p], prev[p]);
    end
endmodule

// File: rtl/gpio_group_regs.sv
module gpio_group_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PINS   = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_trig,
    input  logic                         wr_mask,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [PINS-1:0]              clr,
    input  logic [PINS-1:0]              hit,
    output logic [PINS*TRIG_FIELD_W-1:0] trig_o,
    output logic [PINS-1:0]              mask_o,
    output logic [PINS-1:0]              pend_o,
    output logic                         active_o
);
    localparam int unsigned TRIG_W = PINS * TRIG_FIELD_W;

    typedef struct packed {
        logic [TRIG_W-1:0] trig;
        logic [PINS-1:0]   mask;
        logic [PINS-1:0]   pend;
    } grp_state_t;

    grp_state_t grp_d, grp_q;

    always_comb begin
        grp_d = grp_q;
        if (wr_trig) begin
            grp_d.trig = wdata[TRIG_W-1:0];
        end
        if (wr_mask) begin
            grp_d.mask = wdata[PINS-1:0];
        end
        // A fresh detection outranks an acknowledge in the same cycle.
        grp_d.pend = (grp_q.pend & ~clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q <= '0;
        end else begin
            grp_q <= grp_d;
        end
    end

    assign trig_o   = grp_q.trig;
    assign mask_o   = grp_q.mask;
    assign pend_o   = grp_q.pend;
    assign active_o = |(grp_q.pend & ~grp_q.mask);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 21,
    parameter int unsigned PINS       = 8,
    parameter int unsigned BUS_ADDR_W = 12,
    parameter int unsigned DATA_W     = 32,
    parameter logic [BUS_ADDR_W-1:0] TRIG_BASE = 'h700,
    parameter logic [BUS_ADDR_W-1:0] MASK_BASE = 'h900,
    parameter logic [BUS_ADDR_W-1:0] PEND_BASE = 'hA00
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_GROUPS*PINS-1:0] pin_in,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [BUS_ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       irq_out
);
    localparam int unsigned PIN_CNT = NUM_GROUPS * PINS;
    localparam int unsigned TRIG_W  = PINS * TRIG_FIELD_W;
    localparam int unsigned GRP_W   = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
    localparam logic [BUS_ADDR_W-1:0] BANK_SPAN = BUS_ADDR_W'(4 * NUM_GROUPS);

    // Decoded bus request
    logic [BUS_ADDR_W-1:0] off_trig, off_mask, off_pend;
    bank_e                 bank;
    logic [GRP_W-1:0]      grp_idx;

    // Per-group register views
    logic [TRIG_W-1:0]     trig_w [NUM_GROUPS];
    logic [PINS-1:0]       mask_w [NUM_GROUPS];
    logic [PINS-1:0]       pend_w [NUM_GROUPS];
    logic [NUM_GROUPS-1:0] grp_active;

    // Flattened pin vectors, also seen by the checker
    logic [PIN_CNT-1:0] pend_flat, hit_flat, clr_flat;

    assign off_trig = bus_addr - TRIG_BASE;
    assign off_mask = bus_addr - MASK_BASE;
    assign off_pend = bus_addr - PEND_BASE;

    always_comb begin
        bank    = BANK_NONE;
        grp_idx = '0;
        if (bus_addr[1:0] == 2'b00) begin
            if (off_trig < BANK_SPAN) begin
                bank    = BANK_TRIG;
                grp_idx = off_trig[GRP_W+1:2];
            end else if (off_mask < BANK_SPAN) begin
                bank    = BANK_MASK;
                grp_idx = off_mask[GRP_W+1:2];
            end else if (off_pend < BANK_SPAN) begin
                bank    = BANK_PEND;
                grp_idx = off_pend[GRP_W+1:2];
            end
        end
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
        logic              wr_here;
        logic              wr_trig, wr_mask;
        logic [PINS-1:0]   clr;
        logic [PINS-1:0]   cur, prev, hit;
        logic              primed;

        assign wr_here = bus_sel && bus_wr && (bank != BANK_NONE) &&
                         (grp_idx == GRP_W'(g));
        assign wr_trig = wr_here && (bank == BANK_TRIG);
        assign wr_mask = wr_here && (bank == BANK_MASK);
        assign clr     = (wr_here && (bank == BANK_PEND)) ? bus_wdata[PINS-1:0] : '0;

        gpio_pin_sync #(
            .WIDTH (PINS)
        ) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_raw (pin_in[g*PINS +: PINS]),
            .cur     (cur),
            .prev    (prev),
            .primed  (primed)
        );

        gpio_trig_detect #(
            .PINS (PINS)
        ) u_detect (
            .trig_cfg (trig_w[g]),
            .cur      (cur),
            .prev     (prev),
            .enable   (primed),
            .hit      (hit)
        );

        gpio_group_regs #(
            .PINS   (PINS),
            .DATA_W (DATA_W)
        ) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_trig  (wr_trig),
            .wr_mask  (wr_mask),
            .wdata    (bus_wdata),
            .clr      (clr),
            .hit      (hit),
            .trig_o   (trig_w[g]),
            .mask_o   (mask_w[g]),
            .pend_o   (pend_w[g]),
            .active_o (grp_active[g])
        );

        assign pend_flat[g*PINS +: PINS] = pend_w[g];
        assign hit_flat[g*PINS +: PINS]  = hit;
        assign clr_flat[g*PINS +: PINS]  = clr;
    end

    // Registered read path
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (bus_sel && !bus_wr) begin
            rd_d.rdata = '0;
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (grp_idx == GRP_W'(g)) begin
                    case (bank)
                        BANK_TRIG: rd_d.rdata = DATA_W'(trig_w[g]);
                        BANK_MASK: rd_d.rdata = DATA_W'(mask_w[g]);
                        BANK_PEND: rd_d.rdata = DATA_W'(pend_w[g]);
                        default:   rd_d.rdata = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata = rd_q.rdata;
    assign irq_out   = |grp_active;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
    parameter int unsigned NUM_GROUPS = 21,
    parameter int unsigned PINS       = 8,
    parameter int unsigned BUS_ADDR_W = 12,
    parameter int unsigned DATA_W     = 32,
    parameter logic [BUS_ADDR_W-1:0] MASK_BASE = 'h900,
    parameter logic [BUS_ADDR_W-1:0] PEND_BASE = 'hA00
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [BUS_ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]          bus_rdata,
    input  logic                       irq_out,
    input  logic [NUM_GROUPS*PINS-1:0] pend_vec,
    input  logic [NUM_GROUPS*PINS-1:0] hit_vec,
    input  logic [NUM_GROUPS*PINS-1:0] clr_vec
);
    localparam logic [BUS_ADDR_W-1:0] SPAN = BUS_ADDR_W'(4 * NUM_GROUPS);

    logic [BUS_ADDR_W-1:0] rel_mask, rel_pend;
    logic                  narrow_read;

    assign rel_mask    = bus_addr - MASK_BASE;
    assign rel_pend    = bus_addr - PEND_BASE;
    assign narrow_read = bus_sel && !bus_wr && (bus_addr[1:0] == 2'b00) &&
                         ((rel_mask < SPAN) || (rel_pend < SPAN));

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_out && (pend_vec == '0)));

    assert_narrow_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        narrow_read |=> ((bus_rdata >> PINS) == '0));

    assert_pend_needs_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_vec & ~$past(pend_vec) & ~$past(hit_vec)) == '0));

    assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend_vec) & ~$past(clr_vec) & ~pend_vec) == '0));

    assert_detect_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(hit_vec) & ~pend_vec) == '0));

    assert_irq_drop_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_out) |-> $past(bus_sel && bus_wr));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .PINS       (PINS),
    .BUS_ADDR_W (BUS_ADDR_W),
    .DATA_W     (DATA_W),
    .MASK_BASE  (MASK_BASE),
    .PEND_BASE  (PEND_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .pend_vec  (pend_flat),
    .hit_vec   (hit_flat),
    .clr_vec   (clr_flat)
);

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NG         = 21;
    localparam int P          = 8;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NG*P-1:0]   pins = '1;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_ctrl i_gpio_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pins),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    function automatic logic [11:0] trig_addr(input int g);
        return 12'h700 + 12'(4 * g);
    endfunction
    function automatic logic [11:0] mask_addr(input int g);
        return 12'h900 + 12'(4 * g);
    endfunction
    function automatic logic [11:0] pend_addr(input int g);
        return 12'hA00 + 12'(4 * g);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Walk one pin through high -> low -> high under trigger code m.
    task automatic run_mode(input int g, input int p, input int m);
        string tag;
        logic ea, eb, ec, ed;
        tag = (m > 4) ? "R4 disabled code" : "R3 trigger code";
        wr(trig_addr(g), 32'(m) << (4 * p));
        idle(6);
        wr(pend_addr(g), 32'hFF);
        rd(pend_addr(g), rv);
        ea = (m == 1);
        check($sformatf("%s %0d g%0d p%0d high", tag, m, g, p), rv, 32'(ea) << p);
        pins[g*P+p] = 1'b0;
        idle(6);
        rd(pend_addr(g), rv);
        eb = ea | (m == 0) | (m == 2) | (m == 4);
        check($sformatf("%s %0d g%0d p%0d fall", tag, m, g, p), rv, 32'(eb) << p);
        wr(pend_addr(g), 32'(1) << p);
        rd(pend_addr(g), rv);
        ec = (m == 0);
        check($sformatf("R6 level hold code %0d g%0d p%0d", m, g, p), rv, 32'(ec) << p);
        pins[g*P+p] = 1'b1;
        idle(6);
        rd(pend_addr(g), rv);
        ed = ec | (m == 1) | (m == 3) | (m == 4);
        check($sformatf("%s %0d g%0d p%0d rise", tag, m, g, p), rv, 32'(ed) << p);
        check($sformatf("R7 irq code %0d g%0d p%0d", m, g, p), 32'(irq_out), 32'(ed));
        wr(trig_addr(g), 32'h0);
        idle(4);
        wr(pend_addr(g), 32'hFF);
        rd(pend_addr(g), rv);
        check($sformatf("R5 ack g%0d p%0d", g, p), rv, 32'h0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle(8);

        // R1: reset state with pins held high
        check("R1 irq after reset", 32'(irq_out), 32'h0);
        for (int g = 0; g < NG; g++) begin
            rd(trig_addr(g), rv); check($sformatf("R1 trig g%0d", g), rv, 32'h0);
            rd(mask_addr(g), rv); check($sformatf("R1 mask g%0d", g), rv, 32'h0);
            rd(pend_addr(g), rv); check($sformatf("R1 pend g%0d", g), rv, 32'h0);
        end

        // R2 / R4: readback with only disabled codes, then toggle every pin
        for (int g = 0; g < NG; g++) begin
            logic [31:0] pat;
            pat = '0;
            for (int p = 0; p < P; p++) pat |= 32'(5 + ((g + p) % 11)) << (4 * p);
            wr(trig_addr(g), pat);
            rd(trig_addr(g), rv); check($sformatf("R2 trig readback g%0d", g), rv, pat);
            wr(mask_addr(g), 32'hFFFF_FFFF);
            rd(mask_addr(g), rv); check($sformatf("R2 mask width g%0d", g), rv, 32'h0000_00FF);
        end
        pins = '0; idle(6);
        pins = '1; idle(6);
        for (int g = 0; g < NG; g++) begin
            rd(pend_addr(g), rv); check($sformatf("R4 no pend g%0d", g), rv, 32'h0);
            wr(trig_addr(g), 32'h0);
            wr(mask_addr(g), 32'h0);
        end
        check("R7 irq idle", 32'(irq_out), 32'h0);

        // R3 / R4 / R6: every code on a few pins
        for (int m = 0; m < 16; m++) begin
            run_mode(0, 0, m);
            run_mode(20, 7, m);
            run_mode(10, 3, m);
        end
        // R2 / R3: pin-to-bit mapping for every pin under both-edge code
        for (int g = 0; g < NG; g++) begin
            for (int p = 0; p < P; p++) run_mode(g, p, 4);
        end

        // R7 / R5: masking keeps latching, unmask raises irq next cycle
        wr(trig_addr(5), 32'h2 << 4);
        wr(mask_addr(5), 32'h2);
        pins[5*P+1] = 1'b0;
        idle(6);
        check("R7 masked irq low", 32'(irq_out), 32'h0);
        rd(pend_addr(5), rv); check("R7 latched while masked", rv, 32'h2);
        wr(mask_addr(5), 32'h0);
        check("R7 unmask raises irq", 32'(irq_out), 32'h1);
        wr(pend_addr(5), 32'h0);
        rd(pend_addr(5), rv); check("R5 zero write ignored", rv, 32'h2);
        check("R5 irq kept after zero write", 32'(irq_out), 32'h1);
        wr(pend_addr(5), 32'hFD);
        rd(pend_addr(5), rv); check("R5 other bits ack only", rv, 32'h2);
        wr(mask_addr(5), 32'h2);
        check("R7 remask drops irq", 32'(irq_out), 32'h0);
        wr(mask_addr(5), 32'h0);
        wr(pend_addr(5), 32'h2);
        check("R7 ack drops irq", 32'(irq_out), 32'h0);
        pins[5*P+1] = 1'b1;
        idle(6);
        wr(trig_addr(5), 32'h0);

        // R6 / R3: clear lands on the same edge as a new rising detection
        wr(trig_addr(1), 32'h3 << 8);
        pins[1*P+2] = 1'b0; idle(6);
        pins[1*P+2] = 1'b1; idle(6);
        rd(pend_addr(1), rv); check("R3 rise latched", rv, 32'h4);
        pins[1*P+2] = 1'b0; idle(6);
        pins[1*P+2] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = pend_addr(1); bus_wdata = 32'h4;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd(pend_addr(1), rv); check("R6 detect beats clear", rv, 32'h4);
        wr(pend_addr(1), 32'h4);
        rd(pend_addr(1), rv); check("R5 later clear works", rv, 32'h0);
        wr(trig_addr(1), 32'h0);

        // R8: unmapped and misaligned accesses
        wr(12'h754, 32'hFFFF_FFFF);
        rd(12'h754, rv); check("R8 group past end reads 0", rv, 32'h0);
        wr(12'h751, 32'h1111_1111);
        rd(trig_addr(20), rv); check("R8 misaligned write ignored", rv, 32'h0);
        rd(12'h751, rv); check("R8 misaligned read 0", rv, 32'h0);
        wr(12'h800, 32'hFFFF_FFFF);
        rd(12'h800, rv); check("R8 gap reads 0", rv, 32'h0);
        wr(12'h954, 32'hFFFF_FFFF);
        rd(mask_addr(20), rv); check("R8 mask past end ignored", rv, 32'h0);
        check("R8 irq unaffected", 32'(irq_out), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule